// File: doc/BRIEF.md
# Composite Clock Root Slice

This block derives one output clock from a choice of up to eight source clocks. A source selector picks one input; its edges then pass through two cascaded integer dividers, a 3-bit predivider and a 6-bit post-divider, and finally through an enable gate. All four settings sit in one 32-bit control word. A plain write strobe updates the word, and a readback port returns it.

Each source clock is presented to the slice as a one-cycle tick on the system clock. The output is a one-cycle pulse per completed output period, so the output frequency is the selected source rate divided by the product of the two divisors. The source choice is held in two selection interfaces, A and B. Writes alternate between them, so software writes the same select value twice to make both interfaces agree. Divider and source changes wait for the current output period to finish, and a cleared gate forces them to load at once.

A build parameter picks a core variant. In that variant the predivider is absent and the divider is a single 3-bit field in the low bits.

Top module: `clk_root_slice`

## Requirements
- R1: After reset, the readback word is zero, `clk_out` is low and both `sel_a` and `sel_b` are 0.
- R2: Readback returns the last written fields at their positions and zero in every other bit. The fields are: source select in 26:24, predivider in 18:16, post-divider in 5:0 and gate enable in bit 28.
- R3: While the gate bit reads 0, `clk_out` stays low, whatever the source ticks do.
- R4: With the gate set, `clk_out` pulses once for every (pre+1)*(post+1) ticks of the selected source, where pre and post are the field values. Ticks on the other sources have no effect.
- R5: Every write stores its select field into the interface currently targeted, then moves the target to the other interface. After reset the target is A, so two writes with the same select make `sel_a` equal `sel_b`.
- R6: While the gate is set, new divider and source settings take effect only at the end of a complete output period, so no shortened period occurs. While the gate is clear, new settings load at once and the counters restart.
- R7: In the core variant, only bits 2:0 form the divider and the period is post+1 selected ticks. Bits 18:16 and 5:3 are ignored and read back as 0.
- R8: A pulse on `clk_out` only appears in the cycle right after a tick of the selected source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Stored control word readback |
| src_tick | input | NUM_SRC | One tick per rising edge of each source clock |
| sel_a | output | 3 | Source held by selection interface A |
| sel_b | output | 3 | Source held by selection interface B |
| clk_out | output | 1 | One pulse per output clock period |

## Verification
The hardest case to reach is a divider write that lands in the middle of an output period while the gate is set. A runt would then show up only as one period that is too short among many correct ones. A directed sequence enables the gate with a period of 6 ticks and advances 4 exact ticks. It then rewrites the dividers for a period of 10 and counts pulses at ticks 5, 6, 15 and 16. Randomised settings driven with noisy ticks on the unselected sources cover period lengths and source filtering. A core-variant instance shares the same stimulus.

// File: rtl/clk_root_pkg.sv
package clk_root_pkg;
    localparam int CTRL_W      = 32;
    localparam int SEL_LSB     = 24;
    localparam int SEL_W       = 3;
    localparam int PRE_LSB     = 16;
    localparam int PRE_W       = 3;
    localparam int POST_LSB    = 0;
    localparam int POST_W      = 6;
    localparam int CORE_POST_W = 3;
    localparam int GATE_BIT    = 28;

    typedef struct packed {
        logic [SEL_W-1:0]  sel;
        logic [PRE_W-1:0]  pre;
        logic [POST_W-1:0] post;
        logic              gate;
        logic [SEL_W-1:0]  sel_a;
        logic [SEL_W-1:0]  sel_b;
        logic              tgt_b;
    } regs_t;

    typedef struct packed {
        logic [PRE_W-1:0]  pre_cnt;
        logic [POST_W-1:0] post_cnt;
        logic [PRE_W-1:0]  act_pre;
        logic [POST_W-1:0] act_post;
        logic [SEL_W-1:0]  act_sel;
        logic              out;
    } div_t;

    function automatic logic [CTRL_W-1:0] ctrl_mask(input bit core);
        logic [CTRL_W-1:0] m;
        m = '0;
        m[SEL_LSB +: SEL_W] = '1;
        m[GATE_BIT] = 1'b1;
        if (core) begin
            m[POST_LSB +: CORE_POST_W] = '1;
        end else begin
            m[PRE_LSB +: PRE_W] = '1;
            m[POST_LSB +: POST_W] = '1;
        end
        return m;
    endfunction
endpackage

// File: rtl/clk_root_regs.sv
module clk_root_regs
    import clk_root_pkg::*;
#(
    parameter bit CORE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] rd_data,
    output logic [SEL_W-1:0]  sel_a,
    output logic [SEL_W-1:0]  sel_b,
    output logic [SEL_W-1:0]  sel_live,
    output logic [PRE_W-1:0]  cfg_pre,
    output logic [POST_W-1:0] cfg_post,
    output logic              gate_en
);
    regs_t r_d, r_q;
    logic [PRE_W-1:0]  pre_in;
    logic [POST_W-1:0] post_in;

    generate
        if (CORE) begin : g_core
            assign pre_in  = '0;
            assign post_in = {{(POST_W-CORE_POST_W){1'b0}}, wr_data[POST_LSB +: CORE_POST_W]};
        end else begin : g_full
            assign pre_in  = wr_data[PRE_LSB +: PRE_W];
            assign post_in = wr_data[POST_LSB +: POST_W];
        end
    endgenerate

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            r_d.sel  = wr_data[SEL_LSB +: SEL_W];
            r_d.pre  = pre_in;
            r_d.post = post_in;
            r_d.gate = wr_data[GATE_BIT];
            if (r_q.tgt_b) begin
                r_d.sel_b = wr_data[SEL_LSB +: SEL_W];
            end else begin
                r_d.sel_a = wr_data[SEL_LSB +: SEL_W];
            end
            r_d.tgt_b = !r_q.tgt_b;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rd_data = '0;
        rd_data[SEL_LSB +: SEL_W]   = r_q.sel;
        rd_data[PRE_LSB +: PRE_W]   = r_q.pre;
        rd_data[POST_LSB +: POST_W] = r_q.post;
        rd_data[GATE_BIT]           = r_q.gate;
    end

    // the interface written last is the one opposite the current target
    assign sel_live = r_q.tgt_b ? r_q.sel_a : r_q.sel_b;
    assign sel_a    = r_q.sel_a;
    assign sel_b    = r_q.sel_b;
    assign cfg_pre  = r_q.pre;
    assign cfg_post = r_q.post;
    assign gate_en  = r_q.gate;
endmodule

// File: rtl/clk_root_divchain.sv
module clk_root_divchain
    import clk_root_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_tick,
    input  logic               gate_en,
    input  logic [SEL_W-1:0]   cfg_sel,
    input  logic [PRE_W-1:0]   cfg_pre,
    input  logic [POST_W-1:0]  cfg_post,
    output logic               clk_out,
    output logic               sel_tick,
    output logic               cfg_take,
    output logic [PRE_W-1:0]   act_pre,
    output logic [POST_W-1:0]  act_post
);
    localparam int PAD_W = 1 << SEL_W;

    div_t s_d, s_q;
    logic [PAD_W-1:0] tick_pad;
    logic wrap_pre, wrap_post, period_end;

    always_comb begin
        tick_pad = '0;
        tick_pad[NUM_SRC-1:0] = src_tick;
    end

    assign sel_tick   = tick_pad[s_q.act_sel];
    assign wrap_pre   = (s_q.pre_cnt == s_q.act_pre);
    assign wrap_post  = (s_q.post_cnt == s_q.act_post);
    assign period_end = sel_tick && wrap_pre && wrap_post;
    assign cfg_take   = !gate_en || period_end;

    always_comb begin
        s_d = s_q;
        s_d.out = gate_en && period_end;
        if (!gate_en) begin
            s_d.pre_cnt  = '0;
            s_d.post_cnt = '0;
        end else if (sel_tick) begin
            if (wrap_pre) begin
                s_d.pre_cnt = '0;
                s_d.post_cnt = wrap_post ? '0 : s_q.post_cnt + 1'b1;
            end else begin
                s_d.pre_cnt = s_q.pre_cnt + 1'b1;
            end
        end
        if (cfg_take) begin
            s_d.act_sel  = cfg_sel;
            s_d.act_pre  = cfg_pre;
            s_d.act_post = cfg_post;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign clk_out  = s_q.out;
    assign act_pre  = s_q.act_pre;
    assign act_post = s_q.act_post;
endmodule

// File: rtl/clk_root_slice.sv
module clk_root_slice
    import clk_root_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter bit CORE    = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [31:0]        wr_data,
    output logic [31:0]        rd_data,
    input  logic [NUM_SRC-1:0] src_tick,
    output logic [2:0]         sel_a,
    output logic [2:0]         sel_b,
    output logic               clk_out
);
    logic [SEL_W-1:0]  sel_live;
    logic [PRE_W-1:0]  cfg_pre, act_pre;
    logic [POST_W-1:0] cfg_post, act_post;
    logic              gate_en, sel_tick, cfg_take;

    clk_root_regs #(.CORE(CORE)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .sel_a    (sel_a),
        .sel_b    (sel_b),
        .sel_live (sel_live),
        .cfg_pre  (cfg_pre),
        .cfg_post (cfg_post),
        .gate_en  (gate_en)
    );

    clk_root_divchain #(.NUM_SRC(NUM_SRC)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_tick (src_tick),
        .gate_en  (gate_en),
        .cfg_sel  (sel_live),
        .cfg_pre  (cfg_pre),
        .cfg_post (cfg_post),
        .clk_out  (clk_out),
        .sel_tick (sel_tick),
        .cfg_take (cfg_take),
        .act_pre  (act_pre),
        .act_post (act_post)
    );
endmodule

// File: rtl/clk_root_slice_chk.sv
module clk_root_slice_chk
    import clk_root_pkg::*;
#(
    parameter bit CORE = 1'b0
) (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic [31:0] rd_data,
    input logic [2:0]  sel_a,
    input logic [2:0]  sel_b,
    input logic        clk_out,
    input logic        gate_en,
    input logic        sel_tick,
    input logic        cfg_take,
    input logic [PRE_W-1:0]  act_pre,
    input logic [POST_W-1:0] act_post
);
    localparam logic [31:0] MASK = ctrl_mask(CORE);

    AST_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en) |-> rd_data == ($past(wr_data) & MASK)); // R2

    AST_GATE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_en |=> !clk_out); // R3

    AST_OUT_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        clk_out |-> $past(sel_tick)); // R8

    AST_SEL_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en) && wr_data[26:24] == $past(wr_data[26:24])) |=> sel_a == sel_b); // R5

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(gate_en) && !$past(cfg_take)) |-> ($stable(act_pre) && $stable(act_post))); // R6
endmodule

bind clk_root_slice clk_root_slice_chk #(.CORE(CORE)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .sel_a    (sel_a),
    .sel_b    (sel_b),
    .clk_out  (clk_out),
    .gate_en  (gate_en),
    .sel_tick (sel_tick),
    .cfg_take (cfg_take),
    .act_pre  (act_pre),
    .act_post (act_post)
);

// File: tb/clk_root_slice_tb.sv
module clk_root_slice_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [7:0]  src_tick = '0;
    logic [31:0] rd_data, rd_core;
    logic [2:0]  sel_a, sel_b, sel_a_c, sel_b_c;
    logic        clk_out, clk_out_c;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    int pulses_c = 0;
    int cur_sel = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clk_root_slice #(.NUM_SRC(8), .CORE(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .src_tick(src_tick), .sel_a(sel_a), .sel_b(sel_b), .clk_out(clk_out));

    clk_root_slice #(.NUM_SRC(8), .CORE(1'b1)) u_core (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_core),
        .src_tick(src_tick), .sel_a(sel_a_c), .sel_b(sel_b_c), .clk_out(clk_out_c));

    always @(negedge clk) begin
        pulses   <= pulses + int'(clk_out);
        pulses_c <= pulses_c + int'(clk_out_c);
    end

    function automatic logic [31:0] exp_rd(input logic [31:0] d, input bit core);
        return d & (core ? 32'h1700_0007 : 32'h1707_003F);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int sel, input int pre, input int post, input bit gate);
        logic [31:0] d;
        d = $urandom & ~32'h1707_003F;
        d[26:24] = 3'(sel);
        d[18:16] = 3'(pre);
        d[5:0]   = 6'(post);
        d[28]    = gate;
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        check("R2 readback", int'(rd_data), int'(exp_rd(d, 1'b0)));
        check("R7 core readback", int'(rd_core), int'(exp_rd(d, 1'b1)));
    endtask

    // drive n ticks of the selected source; noisy adds random ticks elsewhere
    task automatic ticks(input int n, input bit noisy);
        int got;
        logic [7:0] v;
        got = 0;
        while (got < n) begin
            @(negedge clk);
            v = noisy ? 8'($urandom) : 8'h00;
            v[cur_sel] = noisy ? v[cur_sel] : 1'b1;
            src_tick = v;
            if (v[cur_sel]) got++;
        end
        @(negedge clk);
        src_tick = '0;
        @(negedge clk);
        #1;
    endtask

    task automatic noise_only(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            src_tick = 8'($urandom);
            src_tick[cur_sel] = 1'b0;
        end
        @(negedge clk);
        src_tick = '0;
        @(negedge clk);
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int b, bc, sel, pre, post, k, pq, q3;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check("R1 rd_data", int'(rd_data), 0);
        check("R1 clk_out", int'(clk_out), 0);
        check("R1 sel_a", int'(sel_a), 0);
        check("R1 sel_b", int'(sel_b), 0);

        // R5: writes alternate A, B, A, B
        wr(5, 0, 0, 1'b0);
        check("R5 first write A", int'(sel_a), 5);
        check("R5 first write B untouched", int'(sel_b), 0);
        wr(5, 0, 0, 1'b0);
        check("R5 second write B", int'(sel_b), 5);
        wr(2, 0, 0, 1'b0);
        check("R5 third write A", int'(sel_a), 2);
        check("R5 third write B held", int'(sel_b), 5);
        wr(2, 0, 0, 1'b0);
        check("R5 pair agrees", int'(sel_b), 2);

        // R3: gate clear, ticks on every source give no pulse
        cur_sel = 2;
        b = pulses; bc = pulses_c;
        wr(2, 0, 0, 1'b0);
        ticks(20, 1'b1);
        check("R3 gate low full", pulses - b, 0);
        check("R3 gate low core", pulses_c - bc, 0);

        // R6: mid-period divider change, period 6 then 10
        cur_sel = 3;
        wr(3, 1, 2, 1'b0);
        wr(3, 1, 2, 1'b1);
        b = pulses;
        ticks(4, 1'b0);
        wr(3, 1, 4, 1'b1);
        ticks(1, 1'b0);
        check("R6 no runt at tick 5", pulses - b, 0);
        ticks(1, 1'b0);
        check("R6 old period ends at tick 6", pulses - b, 1);
        ticks(9, 1'b0);
        check("R6 new period not early at 15", pulses - b, 1);
        ticks(1, 1'b0);
        check("R6 new period at 16", pulses - b, 2);

        // R4 / R7 / R8: random settings with noisy ticks on other sources
        for (int it = 0; it < 24; it++) begin
            sel  = int'($urandom % 8);
            pre  = int'($urandom % 8);
            post = (it < 3) ? 63 - it : int'($urandom % 16);
            if (it == 3) begin pre = 0; post = 0; end
            cur_sel = sel;
            wr(sel, pre, post, 1'b0);
            wr(sel, pre, post, 1'b1);
            check("R5 pair agrees random", int'(sel_a), int'(sel_b));
            pq = (pre + 1) * (post + 1);
            q3 = (post % 8) + 1;
            k = (pq > 100) ? 1 : 1 + int'($urandom % 3);
            b = pulses; bc = pulses_c;
            ticks(k * pq, 1'b1);
            check("R4 period count", pulses - b, k);
            check("R7 core period count", pulses_c - bc, (k * pq) / q3);
            if (pq > 1) begin
                ticks(pq - 1, 1'b1);
                check("R4 no early pulse", pulses - b, k);
            end
            b = pulses;
            noise_only(12);
            check("R8 other sources ignored", pulses - b, 0);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule